// File: doc/BRIEF.md
# Spare Area Scatter Address Generator

This block produces the internal buffer address for every out-of-band (spare) byte of a NAND page as that byte streams into or out of the controller's buffer memory. The spare bytes of a page are split into one chunk per 512-byte sector. Chunk k lands at the start of its own 64-byte spare buffer. The buffers sit at a fixed base, 0x1000, and each one is 0x40 apart from the next. Any bytes left after the even split are appended to buffer 7.

A transfer begins with a one-cycle `start` pulse that carries a page-size code and the spare length. The block then takes one cycle to derive the per-buffer byte count. It does this with a shift, because the sector count is always 1, 4 or 8. After that it presents one address at a time. The consumer moves on to the next byte by raising `advance`. A one-cycle `done` follows the last byte.

The controller walks four named states:
- IDLE → SETUP, taken on `start`.
- SETUP → STREAM, taken when the length is non-zero.
- SETUP → FINISH, taken when the length is zero.
- STREAM → FINISH, taken on the `advance` that consumes the last byte.
- FINISH → IDLE, taken unconditionally.

Top module: `spare_scatter_agen`

## Requirements
- R1: After reset the block is in IDLE, with `addr_valid` and `done` both low.
- R2: A `start` accepted in IDLE is followed by exactly one SETUP cycle. `addr_valid` is high from the second cycle after the start edge and stays high until the last byte is consumed.
- R3: The per-buffer size is (spare_len >> s) with bit 0 cleared. The shift s is 0 for page code 0 (512 bytes), 2 for code 1 (2048 bytes), and 3 for codes 2 and 3 (4096 bytes).
- R4: For spare byte x, the address is 0x1000 + 0x40·b + (x − b·size), where b = x / size limited to 7.
- R5: When the spare length is not a multiple of the per-buffer size, the remaining bytes follow on in buffer 7. For example, with the 4096/218 pair, bytes 208..217 go to 0x11DA..0x11E3.
- R6: While `advance` is low in STREAM, `addr` holds its value.
- R7: `done` is high for exactly one cycle. That cycle follows the `advance` that consumes the final byte, and the block is in IDLE on the next cycle.
- R8: A `start` pulse in SETUP, STREAM or FINISH is ignored. The running transfer's addresses and length are unchanged.
- R9: A start with spare_len 0 gives `done` in the cycle after SETUP, and `addr_valid` never rises.
- R10: `advance` in IDLE has no effect: `addr_valid` stays low, and the next transfer still starts at byte 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a spare transfer; sampled only in IDLE |
| page_code | input | 2 | Page size: 0=512, 1=2048, 2/3=4096 |
| spare_len | input | 8 | Number of spare bytes in the page |
| advance | input | 1 | Current byte consumed; step to the next one |
| addr | output | 13 | Buffer byte address of the current spare byte |
| addr_valid | output | 1 | `addr` holds a live spare byte (STREAM) |
| done | output | 1 | One-cycle pulse after the last byte |

## Verification
The hardest situation to reach is the spill of the remainder into buffer 7. It happens only with the 4096/218 pair, and only after 208 bytes have been stepped through with the index held at its limit. The stimulus therefore drives full transfers of every supported pair under dense, sparse and random `advance` patterns. The reference model computes each expected address with a true division and clamp. It also injects stray `start` pulses mid-transfer and `advance` pulses while idle, and checks that neither disturbs the address sequence.

// File: rtl/sag_pkg.sv
`timescale 1ns/1ps
package sag_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SETUP  = 2'd1,
        ST_STREAM = 2'd2,
        ST_FINISH = 2'd3
    } sag_state_t;

    // log2(page bytes / 512) for a page-size code
    function automatic logic [1:0] sector_shift(input logic [1:0] code);
        logic [1:0] s;
        unique case (code)
            2'd0:    s = 2'd0;
            2'd1:    s = 2'd2;
            default: s = 2'd3;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/sag_size_calc.sv
`timescale 1ns/1ps
module sag_size_calc #(
    parameter int LEN_W = 8
) (
    input  logic [1:0]       page_code,
    input  logic [LEN_W-1:0] spare_len,
    output logic [LEN_W-1:0] sb_size
);
    import sag_pkg::*;

    logic [LEN_W-1:0] shifted;

    always_comb begin
        shifted = spare_len >> sector_shift(page_code);
        sb_size = {shifted[LEN_W-1:1], 1'b0};
    end

endmodule

// File: rtl/sag_pos_counter.sv
`timescale 1ns/1ps
module sag_pos_counter #(
    parameter int          LEN_W      = 8,
    parameter int          NUM_BUFS   = 8,
    parameter int          BUF_BYTES  = 64,
    parameter int          ADDR_W     = 13,
    parameter int unsigned SPARE_BASE = 32'h1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              step,
    input  logic [LEN_W-1:0]  sb_size,
    input  logic [LEN_W-1:0]  spare_len,
    output logic [ADDR_W-1:0] addr,
    output logic              last_byte
);
    localparam int IDX_W = (NUM_BUFS > 1) ? $clog2(NUM_BUFS) : 1;
    localparam int OFF_SH = $clog2(BUF_BYTES);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_BUFS - 1);

    logic [IDX_W-1:0] idx_q;
    logic [LEN_W-1:0] off_q;
    logic [LEN_W-1:0] cnt_q;
    logic             wrap;

    assign wrap = (off_q == sb_size - LEN_W'(1)) && (idx_q != LAST_IDX);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q <= '0;
            off_q <= '0;
            cnt_q <= '0;
        end else if (clear) begin
            idx_q <= '0;
            off_q <= '0;
            cnt_q <= '0;
        end else if (step) begin
            cnt_q <= cnt_q + LEN_W'(1);
            if (wrap) begin
                idx_q <= idx_q + IDX_W'(1);
                off_q <= '0;
            end else begin
                off_q <= off_q + LEN_W'(1);
            end
        end
    end

    always_comb begin
        addr = ADDR_W'(SPARE_BASE)
             + (ADDR_W'(idx_q) << OFF_SH)
             + ADDR_W'(off_q);
        last_byte = (cnt_q == spare_len - LEN_W'(1));
    end

    AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !clear) |=> (idx_q == $past(idx_q) || idx_q == $past(idx_q) + IDX_W'(1))) else $error("idx jump"); // R4
    AST_OFF_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !clear && idx_q != LAST_IDX && off_q == sb_size - LEN_W'(1)) |=> (off_q == '0)) else $error("offset not restarted"); // R4
    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !clear) |=> $stable(addr)) else $error("address moved"); // R6

endmodule

// File: rtl/sag_ctrl.sv
`timescale 1ns/1ps
module sag_ctrl (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic                  advance,
    input  logic                  len_zero,
    input  logic                  last_byte,
    output sag_pkg::sag_state_t   state,
    output logic                  latch_en,
    output logic                  clear,
    output logic                  step,
    output logic                  addr_valid,
    output logic                  done
);
    import sag_pkg::*;

    sag_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = ST_SETUP;
            ST_SETUP:  state_d = len_zero ? ST_FINISH : ST_STREAM;
            ST_STREAM: if (advance && last_byte) state_d = ST_FINISH;
            ST_FINISH: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        latch_en   = 1'b0;
        clear      = 1'b0;
        step       = 1'b0;
        addr_valid = 1'b0;
        done       = 1'b0;
        unique case (state_q)
            ST_IDLE:   latch_en = start;
            ST_SETUP:  clear = 1'b1;
            ST_STREAM: begin
                addr_valid = 1'b1;
                step       = advance;
            end
            ST_FINISH: done = 1'b1;
        endcase
    end

    assign state = state_q;

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && state_q == ST_IDLE)) else $error("done too long"); // R7
    AST_SETUP_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SETUP) |=> (state_q == ST_STREAM || state_q == ST_FINISH)) else $error("setup stuck"); // R2
    AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE && start) |=> (state_q != ST_SETUP)) else $error("restart while busy"); // R8
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !start) |=> (state_q == ST_IDLE && !addr_valid)) else $error("left idle"); // R10

endmodule

// File: rtl/spare_scatter_agen.sv
`timescale 1ns/1ps
module spare_scatter_agen #(
    parameter int          LEN_W      = 8,
    parameter int          NUM_BUFS   = 8,
    parameter int          BUF_BYTES  = 64,
    parameter int          ADDR_W     = 13,
    parameter int unsigned SPARE_BASE = 32'h1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [1:0]        page_code,
    input  logic [LEN_W-1:0]  spare_len,
    input  logic              advance,
    output logic [ADDR_W-1:0] addr,
    output logic              addr_valid,
    output logic              done
);
    import sag_pkg::*;

    sag_state_t       state;
    logic             latch_en, clear, step, last_byte;
    logic [1:0]       page_q;
    logic [LEN_W-1:0] len_q, sb_q, sb_calc;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            page_q <= '0;
            len_q  <= '0;
            sb_q   <= '0;
        end else begin
            if (latch_en) begin
                page_q <= page_code;
                len_q  <= spare_len;
            end
            if (clear) sb_q <= sb_calc;
        end
    end

    sag_size_calc #(.LEN_W(LEN_W)) size_i (
        .page_code (page_q),
        .spare_len (len_q),
        .sb_size   (sb_calc)
    );

    sag_pos_counter #(
        .LEN_W(LEN_W), .NUM_BUFS(NUM_BUFS), .BUF_BYTES(BUF_BYTES),
        .ADDR_W(ADDR_W), .SPARE_BASE(SPARE_BASE)
    ) pos_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (clear),
        .step      (step),
        .sb_size   (sb_q),
        .spare_len (len_q),
        .addr      (addr),
        .last_byte (last_byte)
    );

    sag_ctrl ctrl_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .advance    (advance),
        .len_zero   (len_q == '0),
        .last_byte  (last_byte),
        .state      (state),
        .latch_en   (latch_en),
        .clear      (clear),
        .step       (step),
        .addr_valid (addr_valid),
        .done       (done)
    );

    AST_LEN_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE) |=> $stable(len_q)) else $error("length changed mid-run"); // R8
    AST_ZERO_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SETUP && len_q == '0) |=> (done && !addr_valid)) else $error("empty run streamed"); // R9

endmodule

// File: tb/spare_scatter_agen_tb_top.sv
`timescale 1ns/1ps
module spare_scatter_agen_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  page_code = '0;
    logic [7:0]  spare_len = '0;
    logic        advance = 1'b0;
    logic [12:0] addr;
    logic        addr_valid;
    logic        done;

    int n_checks = 0;
    int n_fails  = 0;
    string scen  = "R1";

    // reference model
    int m_state = 0;   // 0 idle, 1 setup, 2 stream, 3 finish
    int m_len = 0, m_page = 0, m_sb = 0, m_x = 0;
    int exp_q[$];
    bit prev_adv = 1'b0;

    always #2.5 clk = ~clk;

    spare_scatter_agen dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .page_code(page_code),
        .spare_len(spare_len), .advance(advance), .addr(addr),
        .addr_valid(addr_valid), .done(done)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: got 0x%0h expected 0x%0h (byte %0d)", tag, act, exp, m_x);
        end
    endtask

    task automatic compare();
        string t;
        chk(scen, int'(addr_valid), (m_state == 2) ? 1 : 0);
        chk((scen == "R9") ? "R9" : "R7", int'(done), (m_state == 3) ? 1 : 0);
        if (m_state == 2) begin
            if (m_x >= 8 * m_sb)         t = "R5";
            else if (m_x == m_sb)        t = "R3";
            else if (!prev_adv)          t = "R6";
            else if (scen == "R8")       t = "R8";
            else                         t = "R4";
            chk(t, int'(addr), exp_q[m_x]);
        end
    endtask

    task automatic model_step(input bit st, input int pc, input int ln, input bit adv);
        case (m_state)
            0: if (st) begin m_page = pc; m_len = ln; m_state = 1; end
            1: begin
                int sh;
                sh = (m_page == 0) ? 0 : (m_page == 1) ? 2 : 3;
                m_sb = (m_len >> sh) & ~1;
                exp_q.delete();
                for (int x = 0; x < m_len; x++) begin
                    int b;
                    b = x / m_sb;
                    if (b > 7) b = 7;
                    exp_q.push_back(32'h1000 + b * 64 + (x - b * m_sb));
                end
                m_x = 0;
                m_state = (m_len == 0) ? 3 : 2;
            end
            2: if (adv) begin
                if (m_x == m_len - 1) m_state = 3;
                else m_x++;
            end
            default: m_state = 0;
        endcase
    endtask

    task automatic cyc(input bit st, input int pc, input int ln, input bit adv);
        @(negedge clk);
        compare();
        start = st; page_code = 2'(pc); spare_len = 8'(ln); advance = adv;
        model_step(st, pc, ln, adv);
        prev_adv = adv && (m_state == 2 || m_state == 3);
    endtask

    // mode: 0 always advance, 1 every other cycle, 2 random, 3 random with stray starts
    task automatic run(input int pc, input int ln, input int mode);
        int guard;
        cyc(1'b1, pc, ln, 1'b0);
        guard = 0;
        while ((m_state != 0) && guard < 2000) begin
            bit a, s;
            a = (mode == 0) ? 1'b1 : (mode == 1) ? guard[0] : 1'($urandom_range(0, 1));
            s = (mode == 3) ? ($urandom_range(0, 7) == 0) : 1'b0;
            if (mode == 3) scen = "R8";
            cyc(s, (pc + 1) % 4, 7, a);
            guard++;
        end
        scen = "R2";
        cyc(1'b0, 0, 0, 1'b0);
    endtask

    initial begin
        scen = "R1";
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cyc(1'b0, 0, 0, 1'b0);   // R1 reset state
        cyc(1'b0, 0, 0, 1'b0);

        // R10: advance while idle
        scen = "R10";
        repeat (4) cyc(1'b0, 0, 0, 1'b1);
        scen = "R2";
        run(0, 16, 0);
        run(1, 64, 0);
        run(2, 128, 1);
        run(2, 218, 0);
        run(3, 218, 2);
        run(1, 64, 2);
        scen = "R10";
        repeat (3) cyc(1'b0, 0, 0, 1'b1);
        scen = "R2";
        run(2, 218, 3);
        run(0, 16, 3);
        scen = "R9";
        run(1, 0, 0);
        scen = "R2";
        run(2, 128, 0);
        repeat (2) cyc(1'b0, 0, 0, 1'b0);

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: got hang expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule